// File: doc/BRIEF.md
# Translation Buffer with Page-Table Walker

This block turns a logical address, given as a page number and a byte offset, into a physical address. A small fully associative store of page-to-frame pairs is searched in parallel when a lookup is accepted. A hit produces the translation in the next cycle. A miss starts a walk. The walk reads one page-table entry through a simple read port, checks the entry's valid bit, and either returns a translation or reports a page fault. A valid entry is then installed in the store.

Lookups use a valid/ready request channel and a valid/ready response channel. Only one lookup is in flight at a time. `req_ready` is high only while the block is idle. A response stays on the outputs, unchanged, until `rsp_ready` is seen high. The memory read port also has back-pressure: the address is held until `mem_req_ready` is high. The returned entry arrives later on `mem_rsp_valid`, which needs no ready.

A lookup may ask for its fill to be pinned. Replacement never evicts a pinned slot, and flush does not clear it. The flush input clears every slot that is not pinned. The page-table base is a plain input that software holds steady.

Top module: `tlb_walker`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` and `mem_req_valid` are 0, and every slot is empty, so the first lookup of any page misses.
- R2: A lookup that hits is answered in the cycle after acceptance. The answer has `rsp_hit`=1 and `rsp_fault`=0, and no memory read is made.
- R3: A miss makes exactly one memory read at address `pt_base + page*PTE_BYTES` (PTE_BYTES defaults to 4). `mem_req_valid` and `mem_addr` stay stable until `mem_req_ready` is high.
- R4: The page-table entry carries the valid flag in bit PFN_W and the frame number in bits PFN_W-1:0. The physical address is `frame*2^OFF_W + offset`. A valid entry is answered with `rsp_hit`=0 and `rsp_fault`=0, and is installed, so the next lookup of that page hits.
- R5: An entry with a clear valid flag is answered with `rsp_fault`=1, `rsp_paddr`=0 and `rsp_hit`=0. It is not installed, so the same page misses again.
- R6: A fill goes into the lowest-numbered empty slot. When no slot is empty, a round-robin pointer chooses the victim. The pointer is 0 after reset, skips pinned slots, and moves to the slot after each victim it evicts.
- R7: A fill requested with `req_pin`=1 is pinned. A pinned slot is never chosen as a victim and survives flush.
- R8: When every slot is pinned, a fill is not stored, but the translation is still returned. A later lookup of that page misses again.
- R9: A one-cycle `flush` pulse while idle empties every unpinned slot.
- R10: `req_ready` is 1 only while idle. While `rsp_valid`=1 and `rsp_ready`=0, `rsp_paddr`, `rsp_fault` and `rsp_hit` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Empty all unpinned slots |
| pt_base | input | MA_W | Page-table base address |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Block idle, lookup accepted |
| req_vpn | input | VPN_W | Page number |
| req_off | input | OFF_W | Byte offset within the page |
| req_pin | input | 1 | Pin the slot filled by this lookup |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumed |
| rsp_paddr | output | PFN_W+OFF_W | Physical address (0 on fault) |
| rsp_fault | output | 1 | Page fault |
| rsp_hit | output | 1 | Answered from the buffer |
| mem_req_valid | output | 1 | Page-table read request |
| mem_req_ready | input | 1 | Read request taken |
| mem_addr | output | MA_W | Page-table entry address |
| mem_rsp_valid | input | 1 | Entry data valid |
| mem_rsp_data | input | PFN_W+1 | Page-table entry: valid flag and frame |

## Verification
The checker assumes three things about the environment:
- `mem_rsp_valid` is pulsed once, and only after a read request has been taken.
- `pt_base` stays constant during a walk.
- `flush` is pulsed only while the block is idle.

The bench answers each read exactly once, after a random delay, from a page-table function. It holds the base constant and issues flushes only between lookups. Back-pressure on the memory port and on the response channel is applied at random, so the hold rules are exercised under stall.

// File: rtl/tlbw_pkg.sv
package tlbw_pkg;
  typedef enum logic [1:0] {
    W_IDLE  = 2'd0,
    W_MREQ  = 2'd1,
    W_MWAIT = 2'd2,
    W_RESP  = 2'd3
  } walk_st_e;
endpackage

// File: rtl/tlbw_cam.sv
// Fully associative page/frame store with a parallel compare on every slot.
module tlbw_cam #(
  parameter int N     = 4,
  parameter int VPN_W = 8,
  parameter int PFN_W = 6,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic [N-1:0]     match_vec,
  output logic             hit,
  output logic [PFN_W-1:0] hit_pfn,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [VPN_W-1:0] wr_vpn,
  input  logic [PFN_W-1:0] wr_pfn,
  input  logic             wr_pin,
  output logic [N-1:0]     valid_vec,
  output logic [N-1:0]     wired_vec
);
  logic [VPN_W-1:0] tag_q [N];
  logic [PFN_W-1:0] pfn_q [N];
  logic [N-1:0]     valid_q;
  logic [N-1:0]     wired_q;

  for (genvar g = 0; g < N; g++) begin : g_slot
    logic wr_here;
    assign wr_here = wr_en && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_q[g] <= 1'b0;
        wired_q[g] <= 1'b0;
        tag_q[g]   <= '0;
        pfn_q[g]   <= '0;
      end else if (wr_here) begin
        // a slot written in the same cycle as a flush keeps its new pair
        valid_q[g] <= 1'b1;
        wired_q[g] <= wr_pin;
        tag_q[g]   <= wr_vpn;
        pfn_q[g]   <= wr_pfn;
      end else if (flush && !wired_q[g]) begin
        valid_q[g] <= 1'b0;
      end
    end

    assign match_vec[g] = valid_q[g] && (tag_q[g] == lk_vpn);
  end

  always_comb begin
    hit_pfn = '0;
    for (int i = 0; i < N; i++) begin
      if (match_vec[i]) hit_pfn = hit_pfn | pfn_q[i];
    end
  end

  assign hit       = |match_vec;
  assign valid_vec = valid_q;
  assign wired_vec = wired_q;
endmodule

// File: rtl/tlbw_victim.sv
// Slot choice for a fill: lowest empty slot, else round robin over unpinned slots.
module tlbw_victim #(
  parameter int N     = 4,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     valid_vec,
  input  logic [N-1:0]     wired_vec,
  input  logic             adv,
  output logic [IDX_W-1:0] vic_idx,
  output logic             vic_ok,
  output logic             vic_evict
);
  logic [IDX_W-1:0] rr_q;
  logic [IDX_W-1:0] free_idx, rr_idx, cand;
  logic             free_ok, rr_ok;

  always_comb begin
    free_ok  = 1'b0;
    free_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!valid_vec[i]) begin
        free_ok  = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
  end

  always_comb begin
    rr_ok  = 1'b0;
    rr_idx = '0;
    cand   = '0;
    for (int k = N - 1; k >= 0; k--) begin
      cand = rr_q + IDX_W'(k);
      if (!wired_vec[cand]) begin
        rr_ok  = 1'b1;
        rr_idx = cand;
      end
    end
  end

  assign vic_idx   = free_ok ? free_idx : rr_idx;
  assign vic_ok    = free_ok || rr_ok;
  assign vic_evict = !free_ok && rr_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rr_q <= '0;
    else if (adv && vic_evict) rr_q <= rr_idx + IDX_W'(1);
  end
endmodule

// File: rtl/tlbw_walk.sv
// Lookup sequencer: hit answer, page-table read, fault decision, fill request.
module tlbw_walk
  import tlbw_pkg::*;
#(
  parameter int VPN_W     = 8,
  parameter int PFN_W     = 6,
  parameter int OFF_W     = 4,
  parameter int MA_W      = 16,
  parameter int PTE_BYTES = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [MA_W-1:0]        pt_base,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [VPN_W-1:0]       req_vpn,
  input  logic [OFF_W-1:0]       req_off,
  input  logic                   req_pin,
  input  logic                   lk_hit,
  input  logic [PFN_W-1:0]       lk_pfn,
  output logic                   rsp_valid,
  input  logic                   rsp_ready,
  output logic [PFN_W+OFF_W-1:0] rsp_paddr,
  output logic                   rsp_fault,
  output logic                   rsp_hit,
  output logic                   mem_req_valid,
  input  logic                   mem_req_ready,
  output logic [MA_W-1:0]        mem_addr,
  input  logic                   mem_rsp_valid,
  input  logic [PFN_W:0]         mem_rsp_data,
  output logic                   fill_en,
  output logic [VPN_W-1:0]       fill_vpn,
  output logic [PFN_W-1:0]       fill_pfn,
  output logic                   fill_pin
);
  localparam int SH = $clog2(PTE_BYTES);

  walk_st_e                st_q;
  logic [VPN_W-1:0]        vpn_q;
  logic [OFF_W-1:0]        off_q;
  logic                    pin_q;
  logic [PFN_W+OFF_W-1:0]  pa_q;
  logic                    fault_q, hit_q;
  logic                    pte_ok;

  assign pte_ok = mem_rsp_data[PFN_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= W_IDLE;
      vpn_q   <= '0;
      off_q   <= '0;
      pin_q   <= 1'b0;
      pa_q    <= '0;
      fault_q <= 1'b0;
      hit_q   <= 1'b0;
    end else begin
      unique case (st_q)
        W_IDLE: if (req_valid) begin
          vpn_q <= req_vpn;
          off_q <= req_off;
          pin_q <= req_pin;
          if (lk_hit) begin
            pa_q    <= {lk_pfn, req_off};
            fault_q <= 1'b0;
            hit_q   <= 1'b1;
            st_q    <= W_RESP;
          end else begin
            st_q <= W_MREQ;
          end
        end
        W_MREQ: if (mem_req_ready) st_q <= W_MWAIT;
        W_MWAIT: if (mem_rsp_valid) begin
          hit_q   <= 1'b0;
          fault_q <= !pte_ok;
          pa_q    <= pte_ok ? {mem_rsp_data[PFN_W-1:0], off_q} : '0;
          st_q    <= W_RESP;
        end
        W_RESP: if (rsp_ready) st_q <= W_IDLE;
        default: st_q <= W_IDLE;
      endcase
    end
  end

  assign req_ready     = (st_q == W_IDLE);
  assign rsp_valid     = (st_q == W_RESP);
  assign rsp_paddr     = pa_q;
  assign rsp_fault     = fault_q;
  assign rsp_hit       = hit_q;
  assign mem_req_valid = (st_q == W_MREQ);
  assign mem_addr      = pt_base + (MA_W'(vpn_q) << SH);
  assign fill_en       = (st_q == W_MWAIT) && mem_rsp_valid && pte_ok;
  assign fill_vpn      = vpn_q;
  assign fill_pfn      = mem_rsp_data[PFN_W-1:0];
  assign fill_pin      = pin_q;
endmodule

// File: rtl/tlb_walker.sv
module tlb_walker #(
  parameter int ENTRIES   = 4,
  parameter int VPN_W     = 8,
  parameter int PFN_W     = 6,
  parameter int OFF_W     = 4,
  parameter int MA_W      = 16,
  parameter int PTE_BYTES = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   flush,
  input  logic [MA_W-1:0]        pt_base,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [VPN_W-1:0]       req_vpn,
  input  logic [OFF_W-1:0]       req_off,
  input  logic                   req_pin,
  output logic                   rsp_valid,
  input  logic                   rsp_ready,
  output logic [PFN_W+OFF_W-1:0] rsp_paddr,
  output logic                   rsp_fault,
  output logic                   rsp_hit,
  output logic                   mem_req_valid,
  input  logic                   mem_req_ready,
  output logic [MA_W-1:0]        mem_addr,
  input  logic                   mem_rsp_valid,
  input  logic [PFN_W:0]         mem_rsp_data
);
  localparam int IDX_W = $clog2(ENTRIES);

  logic [ENTRIES-1:0] cam_match, valid_vec, wired_vec;
  logic               lk_hit;
  logic [PFN_W-1:0]   lk_pfn;
  logic               fill_en, fill_pin, vic_ok, vic_evict;
  logic [VPN_W-1:0]   fill_vpn;
  logic [PFN_W-1:0]   fill_pfn;
  logic [IDX_W-1:0]   vic_idx;

  tlbw_cam #(.N(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W), .IDX_W(IDX_W)) u_cam (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .lk_vpn(req_vpn), .match_vec(cam_match), .hit(lk_hit), .hit_pfn(lk_pfn),
    .wr_en(fill_en && vic_ok), .wr_idx(vic_idx), .wr_vpn(fill_vpn),
    .wr_pfn(fill_pfn), .wr_pin(fill_pin),
    .valid_vec(valid_vec), .wired_vec(wired_vec)
  );

  tlbw_victim #(.N(ENTRIES), .IDX_W(IDX_W)) u_vic (
    .clk(clk), .rst_n(rst_n), .valid_vec(valid_vec), .wired_vec(wired_vec),
    .adv(fill_en), .vic_idx(vic_idx), .vic_ok(vic_ok), .vic_evict(vic_evict)
  );

  tlbw_walk #(.VPN_W(VPN_W), .PFN_W(PFN_W), .OFF_W(OFF_W), .MA_W(MA_W),
              .PTE_BYTES(PTE_BYTES)) u_walk (
    .clk(clk), .rst_n(rst_n), .pt_base(pt_base),
    .req_valid(req_valid), .req_ready(req_ready), .req_vpn(req_vpn),
    .req_off(req_off), .req_pin(req_pin), .lk_hit(lk_hit), .lk_pfn(lk_pfn),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr),
    .rsp_fault(rsp_fault), .rsp_hit(rsp_hit),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_addr(mem_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data),
    .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn),
    .fill_pin(fill_pin)
  );
endmodule

// File: rtl/tlb_walker_chk.sv
module tlb_walker_chk #(
  parameter int ENTRIES = 4,
  parameter int PA_W    = 10,
  parameter int MA_W    = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_ready,
  input logic               lk_hit,
  input logic               rsp_valid,
  input logic               rsp_ready,
  input logic [PA_W-1:0]    rsp_paddr,
  input logic               rsp_fault,
  input logic               rsp_hit,
  input logic               mem_req_valid,
  input logic               mem_req_ready,
  input logic [MA_W-1:0]    mem_addr,
  input logic [ENTRIES-1:0] cam_match,
  input logic [ENTRIES-1:0] wired_vec,
  input logic [ENTRIES-1:0] valid_vec
);
  assert_hit_next_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && lk_hit) |=> (rsp_valid && rsp_hit && !rsp_fault));

  assert_mem_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_addr)));

  assert_single_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cam_match));

  assert_fault_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_paddr == '0 && !rsp_hit));

  assert_pin_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((wired_vec & ~valid_vec) == '0));

  assert_rsp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr)
                                   && $stable(rsp_fault) && $stable(rsp_hit)));

  assert_idle_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!rsp_valid && !mem_req_valid));
endmodule

bind tlb_walker tlb_walker_chk #(.ENTRIES(ENTRIES), .PA_W(PFN_W+OFF_W), .MA_W(MA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .lk_hit(lk_hit), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault), .rsp_hit(rsp_hit),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_addr(mem_addr), .cam_match(cam_match), .wired_vec(wired_vec),
  .valid_vec(valid_vec)
);

// File: tb/tlb_walker_tb.sv
module tlb_walker_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NSLOT = 4;
  localparam logic [15:0] PT_BASE = 16'h1200;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [7:0]  req_vpn = '0;
  logic [3:0]  req_off = '0;
  logic        req_pin = 1'b0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [9:0]  rsp_paddr;
  logic        rsp_fault, rsp_hit;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [15:0] mem_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [6:0]  mem_rsp_data = '0;

  int n_chk = 0;
  int n_fail = 0;

  bit m_valid [NSLOT];
  bit m_wired [NSLOT];
  int m_vpn   [NSLOT];
  int m_pfn   [NSLOT];
  int m_rr;

  always #(CLK_PERIOD/2) clk = ~clk;

  tlb_walker u_dut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .pt_base(PT_BASE),
    .req_valid(req_valid), .req_ready(req_ready), .req_vpn(req_vpn),
    .req_off(req_off), .req_pin(req_pin), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
    .rsp_hit(rsp_hit), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_addr(mem_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  // page table contents: valid unless page%5==2, frame = (3*page+1) mod 64
  function automatic logic [6:0] pte_of(input int vpn);
    logic [5:0] fr;
    fr = 6'((vpn * 3 + 1) % 64);
    return {((vpn % 5) != 2), fr};
  endfunction

  function automatic int m_find(input int vpn);
    for (int i = 0; i < NSLOT; i++) if (m_valid[i] && m_vpn[i] == vpn) return i;
    return -1;
  endfunction

  task automatic m_install(input int vpn, input int pfn, input bit pin);
    int idx = -1;
    for (int i = NSLOT - 1; i >= 0; i--) if (!m_valid[i]) idx = i;
    if (idx < 0) begin
      for (int k = NSLOT - 1; k >= 0; k--)
        if (!m_wired[(m_rr + k) % NSLOT]) idx = (m_rr + k) % NSLOT;
      if (idx >= 0) m_rr = (idx + 1) % NSLOT;
    end
    if (idx >= 0) begin
      m_valid[idx] = 1'b1; m_wired[idx] = pin; m_vpn[idx] = vpn; m_pfn[idx] = pfn;
    end
  endtask

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; req_valid = 1'b0; rsp_ready = 1'b0; flush = 1'b0;
    mem_req_ready = 1'b0; mem_rsp_valid = 1'b0;
    for (int i = 0; i < NSLOT; i++) begin m_valid[i] = 0; m_wired[i] = 0; end
    m_rr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic do_flush();
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    for (int i = 0; i < NSLOT; i++) if (!m_wired[i]) m_valid[i] = 0;
  endtask

  task automatic xlat(input int vpn, input int off, input bit pin, input string tag);
    int idx = m_find(vpn);
    bit exp_hit = (idx >= 0);
    logic [6:0] pte = pte_of(vpn);
    bit exp_fault = !exp_hit && !pte[6];
    int exp_pa;
    int nrd = 0;
    int waitc = 0;
    if (exp_hit) exp_pa = m_pfn[idx] * 16 + off;
    else if (pte[6]) exp_pa = int'(pte[5:0]) * 16 + off;
    else exp_pa = 0;
    @(negedge clk);
    chk(req_ready, {tag, " R10 idle before request"}, req_ready, 1);
    req_valid = 1'b1; req_vpn = 8'(vpn); req_off = 4'(off); req_pin = pin;
    @(negedge clk);
    req_valid = 1'b0; req_pin = 1'b0;
    while (!rsp_valid && waitc < 100) begin
      if (mem_req_valid) begin
        chk(mem_addr == 16'(int'(PT_BASE) + vpn * 4), {tag, " R3 entry address"},
            mem_addr, int'(PT_BASE) + vpn * 4);
        if ($urandom % 2 == 1) begin
          mem_req_ready = 1'b1;
          @(negedge clk);
          mem_req_ready = 1'b0;
          nrd++;
          repeat ($urandom % 3) @(negedge clk);
          mem_rsp_valid = 1'b1; mem_rsp_data = pte;
          @(negedge clk);
          mem_rsp_valid = 1'b0;
        end else begin
          @(negedge clk);
        end
      end else begin
        @(negedge clk);
      end
      waitc++;
    end
    chk(rsp_valid, {tag, " R10 response arrives"}, rsp_valid, 1);
    if (exp_hit) chk(waitc == 0, {tag, " R2 hit latency"}, waitc, 0);
    chk(nrd == (exp_hit ? 0 : 1), {tag, " R3 memory reads"}, nrd, exp_hit ? 0 : 1);
    chk(rsp_hit == exp_hit, {tag, " R2 hit flag"}, rsp_hit, exp_hit);
    chk(rsp_fault == exp_fault, {tag, " R5 fault flag"}, rsp_fault, exp_fault);
    chk(rsp_paddr == 10'(exp_pa), {tag, " R4 physical address"}, rsp_paddr, exp_pa);
    repeat ($urandom % 3) begin
      @(negedge clk);
      chk(rsp_valid && rsp_paddr == 10'(exp_pa) && rsp_hit == exp_hit,
          {tag, " R10 response held"}, rsp_paddr, exp_pa);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(req_ready && !rsp_valid, {tag, " R10 back to idle"}, req_ready, 1);
    if (!exp_hit && pte[6]) m_install(vpn, int'(pte[5:0]), pin);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired actual=%0h expected=%0h", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    do_reset();
    chk(req_ready == 1'b1, "R1 req_ready after reset", req_ready, 1);
    chk(rsp_valid == 1'b0, "R1 rsp_valid after reset", rsp_valid, 0);
    chk(mem_req_valid == 1'b0, "R1 mem_req_valid after reset", mem_req_valid, 0);

    // R1 / R4: first access misses, second hits (page 3 -> frame 10)
    xlat(3, 5, 0, "R1");
    xlat(3, 9, 0, "R4");
    // R5: page 7 has a clear valid flag; never installed
    xlat(7, 1, 0, "R5");
    xlat(7, 2, 0, "R5");
    // R6: fill slots 1..3, then evict slot 0 and slot 1 in turn
    xlat(1, 0, 0, "R6"); xlat(4, 0, 0, "R6"); xlat(5, 0, 0, "R6");
    xlat(6, 0, 0, "R6"); xlat(8, 0, 0, "R6");
    xlat(3, 4, 0, "R6"); xlat(4, 4, 0, "R6");
    // R9: flush empties unpinned slots
    do_flush();
    xlat(4, 7, 0, "R9");

    // R7: pinned slot survives eviction and flush
    do_reset();
    xlat(9, 3, 1, "R7");
    xlat(10, 0, 0, "R7"); xlat(11, 0, 0, "R7"); xlat(13, 0, 0, "R7");
    xlat(14, 0, 0, "R7"); xlat(9, 6, 0, "R7");
    do_flush();
    xlat(9, 8, 0, "R7"); xlat(11, 8, 0, "R9");

    // R8: every slot pinned, fill dropped but translation returned
    do_reset();
    xlat(0, 1, 1, "R8"); xlat(1, 1, 1, "R8"); xlat(3, 1, 1, "R8"); xlat(4, 1, 1, "R8");
    xlat(6, 2, 0, "R8"); xlat(6, 3, 0, "R8"); xlat(0, 15, 0, "R8");
    do_flush();
    xlat(3, 0, 0, "R8");

    // constrained random traffic
    do_reset();
    for (int n = 0; n < 400; n++) begin
      if (n % 50 == 49) do_reset();
      else if ($urandom % 20 == 0) do_flush();
      else xlat(int'($urandom % 16), int'($urandom % 16), ($urandom % 16) == 0, "R6");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule